// File: doc/BRIEF.md
# Counter-Ramp ADC Controller

This block is the digital control of a staircase analog-to-digital converter. It owns a binary counter whose value is the code of an external DAC, and it reads one comparator bit that goes high once the DAC level is above the sampled analog input. The DAC, the comparator and the sample-and-hold stay outside the block.

A start pulse that arrives while the block is idle clears the counter and begins a ramp. The code then rises by one on every clock. On the first clock where the comparator is high, the current code becomes the result, a one-cycle done pulse is issued, and the counter goes back to zero. The code is therefore the smallest DAC step whose level is above the input. With a 20 mV step and a 4.36 V input, that code is 219. Conversion time follows the input level and can reach the full code range. If the counter reaches all-ones and the comparator has still not tripped, the block stops there and marks the result as overrange.

Top module: `counter_ramp_adc`

## Requirements
- R1: While reset is held and after it is released, busy_o, done_o, overrange_o, result_o and dac_code_o are all zero.
- R2: A start_i pulse sampled while idle sets busy_o on the next clock, and dac_code_o is 0 at that point.
- R3: While busy with cmp_above_i low and dac_code_o below all-ones, dac_code_o rises by exactly one on each clock.
- R4: When cmp_above_i is high while busy, on the next clock result_o equals the code that was being driven, overrange_o is 0, done_o is 1 for exactly one cycle, and busy_o is 0.
- R5: While idle, dac_code_o is zero.
- R6: When dac_code_o is all-ones while busy and cmp_above_i is low, on the next clock result_o is all-ones, overrange_o is 1 and done_o pulses. If the comparator is high at all-ones, the case is an ordinary trip with overrange_o 0.
- R7: start_i while busy has no effect: the ramp continues and the result and its timing are unchanged.
- R8: result_o and overrange_o hold their values until the next conversion completes.
- R9: done_o rises R+1 clocks after the clock edge that accepts start, where R is the result code, or 2^CODE_W clocks for an overrange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Conversion request, honoured only while idle |
| cmp_above_i | input | 1 | Comparator: 1 when the DAC level is above the held input |
| dac_code_o | output | CODE_W | Code driven to the external DAC |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse when a new result is loaded |
| result_o | output | CODE_W | Last conversion result |
| overrange_o | output | 1 | Last result hit all-ones without a comparator trip |

## Verification
The DAC and comparator are modelled by an integer input level, and the comparator is high when the code exceeds that level. Directed levels cover an input below zero (immediate trip, result 0), the 4.36 V case (219), one step below full scale (a trip exactly at all-ones, no overrange), and levels at or above full scale (overrange). These separate the trip path from the saturation path and check the priority between them. Random levels across and beyond the range check the result and the level-dependent conversion time. Extra start pulses during a ramp and level changes while idle show that neither can move the result.

// File: rtl/adc_ramp_pkg.sv
package adc_ramp_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RAMP = 1'b1
  } ramp_state_e;
endpackage

// File: rtl/ramp_rst_sync.sv
module ramp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/ramp_counter.sv
module ramp_counter #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  output logic [CODE_W-1:0] code,
  output logic              at_max
);
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

  logic [CODE_W-1:0] code_d;
  logic              code_en;

  always_comb begin
    code_en = clr | inc;
    code_d  = clr ? '0 : code + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code <= '0;
    else if (code_en) code <= code_d;
  end

  assign at_max = (code == CODE_MAX);
endmodule

// File: rtl/ramp_ctrl.sv
module ramp_ctrl
  import adc_ramp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cmp_above,
  input  logic at_max,
  output logic busy,
  output logic cnt_clr,
  output logic cnt_inc,
  output logic finish,
  output logic ovr_hit
);
  ramp_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    finish  = 1'b0;
    ovr_hit = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          cnt_clr = 1'b1;
          state_d = ST_RAMP;
        end
      end
      ST_RAMP: begin
        if (cmp_above) begin
          finish  = 1'b1;
          cnt_clr = 1'b1;
          state_d = ST_IDLE;
        end else if (at_max) begin
          finish  = 1'b1;
          ovr_hit = 1'b1;
          cnt_clr = 1'b1;
          state_d = ST_IDLE;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy = (state_q == ST_RAMP);
endmodule

// File: rtl/ramp_result.sv
module ramp_result #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              ovr_in,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] result,
  output logic              overrange,
  output logic              done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result    <= '0;
      overrange <= 1'b0;
    end else if (load) begin
      result    <= code_in;
      overrange <= ovr_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= load;
  end
endmodule

// File: rtl/counter_ramp_adc.sv
module counter_ramp_adc #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              cmp_above_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [CODE_W-1:0] result_o,
  output logic              overrange_o
);
  logic rst_n_int;
  logic at_max, cnt_clr, cnt_inc, finish, ovr_hit;

  ramp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  ramp_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .start     (start_i),
    .cmp_above (cmp_above_i),
    .at_max    (at_max),
    .busy      (busy_o),
    .cnt_clr   (cnt_clr),
    .cnt_inc   (cnt_inc),
    .finish    (finish),
    .ovr_hit   (ovr_hit)
  );

  ramp_counter #(.CODE_W(CODE_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .clr    (cnt_clr),
    .inc    (cnt_inc),
    .code   (dac_code_o),
    .at_max (at_max)
  );

  ramp_result #(.CODE_W(CODE_W)) u_res (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .load      (finish),
    .ovr_in    (ovr_hit),
    .code_in   (dac_code_o),
    .result    (result_o),
    .overrange (overrange_o),
    .done      (done_o)
  );
endmodule

// File: rtl/counter_ramp_adc_chk.sv
module counter_ramp_adc_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              cmp_above_i,
  input logic [CODE_W-1:0] dac_code_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [CODE_W-1:0] result_o,
  input logic              overrange_o
);
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && dac_code_o == '0)); // R2

  AST_CODE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !cmp_above_i && dac_code_o != CODE_MAX) |=>
      (busy_o && dac_code_o == $past(dac_code_o) + 1'b1)); // R3

  AST_TRIP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && cmp_above_i) |=>
      (done_o && !busy_o && !overrange_o && result_o == $past(dac_code_o))); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R4

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (dac_code_o == '0)); // R5

  AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !cmp_above_i && dac_code_o == CODE_MAX) |=>
      (done_o && overrange_o && result_o == CODE_MAX)); // R6

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !cmp_above_i && dac_code_o != CODE_MAX) |=>
      (busy_o && dac_code_o == $past(dac_code_o) + 1'b1)); // R7

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(result_o) && $stable(overrange_o))); // R8

  AST_OVR_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    overrange_o |-> (result_o == CODE_MAX)); // R6
endmodule

bind counter_ramp_adc counter_ramp_adc_chk #(.CODE_W(CODE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .cmp_above_i (cmp_above_i),
  .dac_code_o  (dac_code_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .result_o    (result_o),
  .overrange_o (overrange_o)
);

// File: tb/counter_ramp_adc_tb_top.sv
module counter_ramp_adc_tb_top;
  localparam int CODE_W = 8;
  localparam int MAXV   = (1 << CODE_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic              cmp_above_i;
  logic [CODE_W-1:0] dac_code_o;
  logic              busy_o, done_o, overrange_o;
  logic [CODE_W-1:0] result_o;

  int level = 0;
  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  // behavioural DAC + comparator: high once the code is above the input level
  always_comb cmp_above_i = (int'(dac_code_o) > level);

  counter_ramp_adc #(.CODE_W(CODE_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_above_i(cmp_above_i),
    .dac_code_o(dac_code_o), .busy_o(busy_o), .done_o(done_o),
    .result_o(result_o), .overrange_o(overrange_o)
  );

  function automatic int exp_result(int lvl);
    if (lvl < 0)       return 0;
    if (lvl >= MAXV)   return MAXV;
    return lvl + 1;
  endfunction

  function automatic int exp_ovr(int lvl);
    return (lvl >= MAXV) ? 1 : 0;
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // run one conversion; extra_start pulses start while busy
  task automatic convert(int lvl, bit extra_start);
    int n;
    level = lvl;
    @(negedge clk);
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    check("R2 busy after start", int'(busy_o), 1);
    check("R2 code zero at ramp start", int'(dac_code_o), 0);
    n = 1;
    while (!done_o && n < 400) begin
      if (extra_start && n == 3) start_i = 1'b1;
      else start_i = 1'b0;
      @(negedge clk);
      if (!done_o) n++;
    end
    start_i = 1'b0;
    check(extra_start ? "R7 result with start while busy" : "R4 result",
          int'(result_o), exp_result(lvl));
    check("R6 overrange flag", int'(overrange_o), exp_ovr(lvl));
    check(extra_start ? "R7 timing with start while busy" : "R9 conversion clocks",
          n, exp_result(lvl) + 1);
    check("R4 busy low at done", int'(busy_o), 0);
    @(negedge clk);
    check("R4 done one cycle", int'(done_o), 0);
    check("R5 idle code zero", int'(dac_code_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    int r_hold, o_hold;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 reset busy", int'(busy_o), 0);
    check("R1 reset done", int'(done_o), 0);
    check("R1 reset result", int'(result_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release result", int'(result_o), 0);
    check("R1 after release overrange", int'(overrange_o), 0);
    check("R1 after release code", int'(dac_code_o), 0);

    convert(218, 0);          // 4.36 V / 20 mV -> 219
    convert(-1, 0);           // immediate trip -> 0
    convert(0, 0);
    convert(MAXV - 1, 0);     // trips exactly at all-ones, no overrange (R6)
    convert(MAXV, 0);         // R6 saturation
    convert(MAXV + 40, 0);
    convert(100, 1);          // R7

    // R8: result holds while idle and the input moves
    r_hold = int'(result_o);
    o_hold = int'(overrange_o);
    for (int i = 0; i < 20; i++) begin
      level = i * 17 - 5;
      @(negedge clk);
    end
    check("R8 result held", int'(result_o), r_hold);
    check("R8 overrange held", int'(overrange_o), o_hold);
    convert(MAXV + 3, 0);
    r_hold = int'(overrange_o);
    convert(10, 0);
    check("R8 overrange cleared by next result", int'(overrange_o), 0);

    for (int i = 0; i < 25; i++) begin
      int lvl;
      lvl = int'($urandom_range(0, 300)) - 10;
      convert(lvl, (i % 4) == 1);
    end
    summary();
  end
endmodule